// File: doc/BRIEF.md
# Ethernet MAC Statistics Counter Bank

This block holds the traffic statistics of an Ethernet MAC. The transmit and receive datapaths each give it one strobe per finished frame, with side-band flags and a length or octet count. The bank turns these strobes into counter increments. A simple read port lets software fetch the counters. The register window runs from byte offset 0x100 to 0x1B0.

Every counter clears when it is read. An event that arrives in the same cycle as the read is kept: it becomes the first count after the clear. Counters stop at their all-ones value and do not wrap. The transmitted-octet total is 48 bits wide, so it is read through two words. Reading the low word also copies the upper bits into a holding register, and that register is what the high word returns. A low/high pair of reads therefore describes one instant.

Received frames are sorted into two length bins. Frames that were not received correctly go to an error counter alone. Only bits [ADDR_W-1:2] of the address select a register; the two lowest address bits are ignored inside the window.

Top module: `mac_stat_bank`

## Requirements
- R1: After reset every counter and the octet high holding register are zero, and `rd_data` is zero.
- R2: Each `tx_frm_vld` strobe adds `tx_octets` to a 48-bit octet total. A read at 0x100 returns bits 31:0 of that total.
- R3: A read at 0x100 clears the whole 48-bit total and copies bits 47:32 into a holding register. A read at 0x104 returns that holding register and clears it. Events after the low read do not change what the following high read returns.
- R4: Each `tx_frm_vld` strobe counts one frame at 0x108. When `tx_is_bcast` is set it also counts at 0x10C. When `tx_is_mcast` is set it also counts at 0x110.
- R5: A received frame with `rx_frm_vld` and `rx_ok` both high counts at 0x114 when `rx_is_bcast` is set, at 0x118 when `rx_is_mcast` is set, and at 0x11C when `rx_is_pause` is set.
- R6: A good received frame with `rx_len` exactly 64 counts at 0x120. One with `rx_len` from 65 to 127 counts at 0x124. Any other length counts in neither bin.
- R7: A received frame with `rx_ok` low increments the error counter at 0x128. It changes no other receive counter, whatever its flags and length.
- R8: Frame counters are CNT_W bits wide and hold at 2^CNT_W-1 when further events arrive.
- R9: `rd_data` carries the value selected by `rd_addr` in the cycle after `rd_en`, and zero in cycles after no read. The read clears the counter. An event in the read cycle leaves the counter at the event's increment.
- R10: A read at an address outside 0x100..0x1B0, or at an in-window address above 0x128, returns zero and clears no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_frm_vld | input | 1 | One-cycle strobe: a frame was transmitted |
| tx_octets | input | LEN_W | Octet count of the transmitted frame |
| tx_is_bcast | input | 1 | Transmitted frame was broadcast |
| tx_is_mcast | input | 1 | Transmitted frame was multicast |
| rx_frm_vld | input | 1 | One-cycle strobe: a frame reception ended |
| rx_ok | input | 1 | The received frame was good |
| rx_len | input | LEN_W | Length in bytes of the received frame |
| rx_is_bcast | input | 1 | Received frame was broadcast |
| rx_is_mcast | input | 1 | Received frame was multicast |
| rx_is_pause | input | 1 | Received frame was a pause frame |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | 32 | Read result, valid the cycle after `rd_en` |

## Verification
The transmit counters are driven with frames that carry different flag mixes, so a swapped broadcast/multicast routing shows up. Receive lengths 63, 64, 65, 127 and 128 sit on each side of both bin edges and catch off-by-one limits. A bad frame carries every flag and a 64-byte length, so any leak into a good-frame counter is visible. A run of 65,538 transmit frames carries the octet total across bit 32, with an event placed between the low and high reads. This separates a coherent holding register from a live view of the upper bits, and it also drives the frame counter into saturation. A read placed in the same cycle as an event tells a lossless clear from a plain clear.

// File: rtl/mac_stat_pkg.sv
package mac_stat_pkg;

    // register window in byte offsets
    localparam int WIN_BASE = 'h100;
    localparam int WIN_LAST = 'h1B0;

    // word slots inside the window
    localparam int SLOT_OCT_LO = 0;
    localparam int SLOT_OCT_HI = 1;
    localparam int SLOT_EV0    = 2;

    // event counter indices (slot = SLOT_EV0 + index)
    localparam int EV_TX_FRM    = 0;
    localparam int EV_TX_BC     = 1;
    localparam int EV_TX_MC     = 2;
    localparam int EV_RX_BC     = 3;
    localparam int EV_RX_MC     = 4;
    localparam int EV_RX_PAUSE  = 5;
    localparam int EV_RX_LEN64  = 6;
    localparam int EV_RX_LEN127 = 7;
    localparam int EV_RX_ERR    = 8;
    localparam int NUM_EV       = 9;
    localparam int EV_SEL_W     = 4;

    // length bin edges
    localparam int BIN_A_LEN = 64;
    localparam int BIN_B_LO  = 65;
    localparam int BIN_B_HI  = 127;

    typedef enum logic [1:0] {
        RD_NONE   = 2'd0,
        RD_OCT_LO = 2'd1,
        RD_OCT_HI = 2'd2,
        RD_EV     = 2'd3
    } rd_kind_e;

    typedef struct packed {
        rd_kind_e              kind;
        logic [EV_SEL_W-1:0]   ev_sel;
    } rd_dec_t;

    typedef struct packed {
        logic vld;
        logic bc;
        logic mc;
    } tx_flags_t;

    typedef struct packed {
        logic vld;
        logic ok;
        logic bc;
        logic mc;
        logic pause;
    } rx_flags_t;

    // map a byte address onto the register kind it selects
    function automatic rd_dec_t decode_addr(input logic [31:0] addr);
        rd_dec_t d;
        int      slot;
        d.kind   = RD_NONE;
        d.ev_sel = '0;
        if (addr >= 32'(WIN_BASE) && addr <= 32'(WIN_LAST)) begin
            slot = (int'(addr) - WIN_BASE) / 4;
            if (slot == SLOT_OCT_LO) begin
                d.kind = RD_OCT_LO;
            end else if (slot == SLOT_OCT_HI) begin
                d.kind = RD_OCT_HI;
            end else if (slot < SLOT_EV0 + NUM_EV) begin
                d.kind   = RD_EV;
                d.ev_sel = EV_SEL_W'(slot - SLOT_EV0);
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/mac_stat_counter.sv
module mac_stat_counter #(
    parameter int W     = 32,
    parameter int AMT_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [AMT_W-1:0] amt,
    output logic [W-1:0]     cnt
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] amt_ext;
    logic [W:0]   sum;

    always_comb begin
        amt_ext             = '0;
        amt_ext[AMT_W-1:0]  = amt;
        sum                 = {1'b0, cnt_q} + {1'b0, amt_ext};
    end

    // clear on read keeps the same-cycle increment; saturate on carry out
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= amt_ext;
        end else if (sum[W]) begin
            cnt_q <= '1;
        end else begin
            cnt_q <= sum[W-1:0];
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/mac_stat_octet.sv
module mac_stat_octet #(
    parameter int OCT_W = 48,
    parameter int LEN_W = 16,
    localparam int HI_W = OCT_W - 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] amt,
    input  logic             rd_lo,
    input  logic             rd_hi,
    output logic [OCT_W-1:0] cnt,
    output logic [HI_W-1:0]  hi_hold
);
    logic [OCT_W-1:0] total;
    logic [HI_W-1:0]  hold_q;

    mac_stat_counter #(
        .W     (OCT_W),
        .AMT_W (LEN_W)
    ) u_total (
        .clk (clk),
        .rst (rst),
        .clr (rd_lo),
        .amt (amt),
        .cnt (total)
    );

    // upper bits frozen at the low read, cleared when read themselves
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (rd_lo) begin
            hold_q <= total[OCT_W-1:32];
        end else if (rd_hi) begin
            hold_q <= '0;
        end
    end

    assign cnt     = total;
    assign hi_hold = hold_q;
endmodule

// File: rtl/mac_stat_ev_decode.sv
module mac_stat_ev_decode
    import mac_stat_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  tx_flags_t          tx,
    input  logic [LEN_W-1:0]   tx_octets,
    input  rx_flags_t          rx,
    input  logic [LEN_W-1:0]   rx_len,
    output logic [NUM_EV-1:0]  ev_inc,
    output logic [LEN_W-1:0]   oct_amt
);
    logic rx_good;
    logic rx_bad;
    logic len_a;
    logic len_b;

    always_comb begin
        rx_good = rx.vld & rx.ok;
        rx_bad  = rx.vld & ~rx.ok;
        len_a   = (rx_len == LEN_W'(BIN_A_LEN));
        len_b   = (rx_len >= LEN_W'(BIN_B_LO)) && (rx_len <= LEN_W'(BIN_B_HI));

        ev_inc               = '0;
        ev_inc[EV_TX_FRM]    = tx.vld;
        ev_inc[EV_TX_BC]     = tx.vld & tx.bc;
        ev_inc[EV_TX_MC]     = tx.vld & tx.mc;
        ev_inc[EV_RX_BC]     = rx_good & rx.bc;
        ev_inc[EV_RX_MC]     = rx_good & rx.mc;
        ev_inc[EV_RX_PAUSE]  = rx_good & rx.pause;
        ev_inc[EV_RX_LEN64]  = rx_good & len_a;
        ev_inc[EV_RX_LEN127] = rx_good & len_b;
        ev_inc[EV_RX_ERR]    = rx_bad;

        oct_amt = tx.vld ? tx_octets : '0;
    end
endmodule

// File: rtl/mac_stat_rd_port.sv
module mac_stat_rd_port
    import mac_stat_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 32,
    parameter int HI_W   = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          rd_en,
    input  logic [ADDR_W-1:0]             rd_addr,
    input  logic [NUM_EV-1:0][CNT_W-1:0]  ev_cnt,
    input  logic [31:0]                   oct_lo,
    input  logic [HI_W-1:0]               oct_hi,
    output logic [NUM_EV-1:0]             ev_clr,
    output logic                          oct_lo_rd,
    output logic                          oct_hi_rd,
    output logic [31:0]                   rd_data
);
    rd_dec_t     dec;
    logic [31:0] mux;
    logic [31:0] data_q;

    always_comb begin
        dec       = decode_addr(32'(rd_addr));
        mux       = '0;
        ev_clr    = '0;
        oct_lo_rd = 1'b0;
        oct_hi_rd = 1'b0;
        case (dec.kind)
            RD_OCT_LO: begin
                mux       = oct_lo;
                oct_lo_rd = rd_en;
            end
            RD_OCT_HI: begin
                mux[HI_W-1:0] = oct_hi;
                oct_hi_rd     = rd_en;
            end
            RD_EV: begin
                for (int i = 0; i < NUM_EV; i++) begin
                    if (dec.ev_sel == EV_SEL_W'(i)) begin
                        mux[CNT_W-1:0] = ev_cnt[i];
                        ev_clr[i]      = rd_en;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (rd_en) begin
            data_q <= mux;
        end else begin
            data_q <= '0;
        end
    end

    assign rd_data = data_q;
endmodule

// File: rtl/mac_stat_bank.sv
module mac_stat_bank
    import mac_stat_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int LEN_W  = 16,
    parameter int CNT_W  = 32,
    parameter int OCT_W  = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_frm_vld,
    input  logic [LEN_W-1:0]  tx_octets,
    input  logic              tx_is_bcast,
    input  logic              tx_is_mcast,
    input  logic              rx_frm_vld,
    input  logic              rx_ok,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic              rx_is_bcast,
    input  logic              rx_is_mcast,
    input  logic              rx_is_pause,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data
);
    localparam int HI_W = OCT_W - 32;

    tx_flags_t                  tx_f;
    rx_flags_t                  rx_f;
    logic [NUM_EV-1:0]          ev_inc;
    logic [NUM_EV-1:0]          ev_clr;
    logic [NUM_EV-1:0][CNT_W-1:0] ev_cnt;
    logic [LEN_W-1:0]           oct_amt;
    logic [OCT_W-1:0]           oct_cnt;
    logic [HI_W-1:0]            oct_hi;
    logic                       oct_lo_rd;
    logic                       oct_hi_rd;

    assign tx_f = '{vld: tx_frm_vld, bc: tx_is_bcast, mc: tx_is_mcast};
    assign rx_f = '{vld: rx_frm_vld, ok: rx_ok, bc: rx_is_bcast,
                    mc: rx_is_mcast, pause: rx_is_pause};

    mac_stat_ev_decode #(
        .LEN_W (LEN_W)
    ) u_dec (
        .tx        (tx_f),
        .tx_octets (tx_octets),
        .rx        (rx_f),
        .rx_len    (rx_len),
        .ev_inc    (ev_inc),
        .oct_amt   (oct_amt)
    );

    for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
        mac_stat_counter #(
            .W     (CNT_W),
            .AMT_W (1)
        ) u_cnt (
            .clk (clk),
            .rst (rst),
            .clr (ev_clr[g]),
            .amt (ev_inc[g]),
            .cnt (ev_cnt[g])
        );
    end

    mac_stat_octet #(
        .OCT_W (OCT_W),
        .LEN_W (LEN_W)
    ) u_oct (
        .clk     (clk),
        .rst     (rst),
        .amt     (oct_amt),
        .rd_lo   (oct_lo_rd),
        .rd_hi   (oct_hi_rd),
        .cnt     (oct_cnt),
        .hi_hold (oct_hi)
    );

    mac_stat_rd_port #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .HI_W   (HI_W)
    ) u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .ev_cnt    (ev_cnt),
        .oct_lo    (oct_cnt[31:0]),
        .oct_hi    (oct_hi),
        .ev_clr    (ev_clr),
        .oct_lo_rd (oct_lo_rd),
        .oct_hi_rd (oct_hi_rd),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/mac_stat_chk.sv
module mac_stat_chk
    import mac_stat_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 32,
    parameter int OCT_W  = 48
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          rd_en,
    input logic [ADDR_W-1:0]             rd_addr,
    input logic [31:0]                   rd_data,
    input logic                          rx_frm_vld,
    input logic                          rx_ok,
    input logic [NUM_EV-1:0][CNT_W-1:0]  ev_cnt,
    input logic [OCT_W-1:0]              oct_cnt
);
    localparam int A_TXF  = WIN_BASE + 4 * (SLOT_EV0 + EV_TX_FRM);
    localparam int A_LAST = WIN_BASE + 4 * (SLOT_EV0 + NUM_EV - 1);

    logic rd_oob;
    assign rd_oob = (rd_addr < ADDR_W'(WIN_BASE)) || (rd_addr > ADDR_W'(WIN_LAST))
                 || (rd_addr > ADDR_W'(A_LAST + 3));

    // R9
    rd_clr_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en && rd_addr == ADDR_W'(A_TXF) |=> ev_cnt[EV_TX_FRM] <= CNT_W'(1));

    // R8
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en && ev_cnt[EV_RX_BC] == '1 |=> ev_cnt[EV_RX_BC] == '1);

    // R7
    err_iso_chk: assert property (@(posedge clk) disable iff (rst)
        rx_frm_vld && !rx_ok && !rd_en |=> $stable(ev_cnt[EV_RX_BC]) && $stable(ev_cnt[EV_RX_MC])
            && $stable(ev_cnt[EV_RX_PAUSE]) && $stable(ev_cnt[EV_RX_LEN64])
            && $stable(ev_cnt[EV_RX_LEN127]));

    // R2
    oct_lo_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en && rd_addr == ADDR_W'(WIN_BASE) |=> rd_data == $past(oct_cnt[31:0]));

    // R10
    oob_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en && rd_oob |=> rd_data == 32'd0);
endmodule

bind mac_stat_bank mac_stat_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .OCT_W  (OCT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .rx_frm_vld (rx_frm_vld),
    .rx_ok      (rx_ok),
    .ev_cnt     (ev_cnt),
    .oct_cnt    (oct_cnt)
);

// File: tb/tb_mac_stat_bank.sv
module tb_mac_stat_bank;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 12;
    localparam int LEN_W  = 16;
    localparam int CNT_W  = 8;
    localparam int OCT_W  = 48;

    localparam logic [11:0] A_OLO  = 12'h100;
    localparam logic [11:0] A_OHI  = 12'h104;
    localparam logic [11:0] A_TXF  = 12'h108;
    localparam logic [11:0] A_TXB  = 12'h10C;
    localparam logic [11:0] A_TXM  = 12'h110;
    localparam logic [11:0] A_RXB  = 12'h114;
    localparam logic [11:0] A_RXM  = 12'h118;
    localparam logic [11:0] A_RXP  = 12'h11C;
    localparam logic [11:0] A_B64  = 12'h120;
    localparam logic [11:0] A_B127 = 12'h124;
    localparam logic [11:0] A_ERR  = 12'h128;

    logic              clk = 0;
    logic              rst = 1;
    logic              tx_frm_vld = 0;
    logic [LEN_W-1:0]  tx_octets = '0;
    logic              tx_is_bcast = 0;
    logic              tx_is_mcast = 0;
    logic              rx_frm_vld = 0;
    logic              rx_ok = 0;
    logic [LEN_W-1:0]  rx_len = '0;
    logic              rx_is_bcast = 0;
    logic              rx_is_mcast = 0;
    logic              rx_is_pause = 0;
    logic              rd_en = 0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [31:0]       rd_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    mac_stat_bank #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .CNT_W  (CNT_W),
        .OCT_W  (OCT_W)
    ) dut (
        .clk         (clk),
        .rst         (rst),
        .tx_frm_vld  (tx_frm_vld),
        .tx_octets   (tx_octets),
        .tx_is_bcast (tx_is_bcast),
        .tx_is_mcast (tx_is_mcast),
        .rx_frm_vld  (rx_frm_vld),
        .rx_ok       (rx_ok),
        .rx_len      (rx_len),
        .rx_is_bcast (rx_is_bcast),
        .rx_is_mcast (rx_is_mcast),
        .rx_is_pause (rx_is_pause),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en   = 1;
        rd_addr = a;
        @(negedge clk);
        rd_en   = 0;
        d       = rd_data;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic tx_ev(input logic [15:0] n, input logic bc, input logic mc);
        @(negedge clk);
        tx_frm_vld = 1; tx_octets = n; tx_is_bcast = bc; tx_is_mcast = mc;
        @(negedge clk);
        tx_frm_vld = 0; tx_octets = '0; tx_is_bcast = 0; tx_is_mcast = 0;
    endtask

    task automatic rx_ev(input logic ok, input logic [15:0] len,
                         input logic bc, input logic mc, input logic ps);
        @(negedge clk);
        rx_frm_vld = 1; rx_ok = ok; rx_len = len;
        rx_is_bcast = bc; rx_is_mcast = mc; rx_is_pause = ps;
        @(negedge clk);
        rx_frm_vld = 0; rx_ok = 0; rx_len = '0;
        rx_is_bcast = 0; rx_is_mcast = 0; rx_is_pause = 0;
    endtask

    // R1
    task automatic t_reset;
        chk("R1 rd_data after reset", rd_data, 32'd0);
        rd_chk("R1 octet low", A_OLO, 0);
        rd_chk("R1 octet high", A_OHI, 0);
        rd_chk("R1 tx frames", A_TXF, 0);
        rd_chk("R1 rx error", A_ERR, 0);
    endtask

    // R2 R4 R9
    task automatic t_tx_basic;
        tx_ev(16'd100, 1, 0);
        tx_ev(16'd200, 0, 1);
        tx_ev(16'd60, 0, 0);
        rd_chk("R2 octet low sum", A_OLO, 32'd360);
        rd_chk("R3 octet high zero", A_OHI, 0);
        rd_chk("R4 tx frames", A_TXF, 3);
        rd_chk("R4 tx bcast", A_TXB, 1);
        rd_chk("R4 tx mcast", A_TXM, 1);
        rd_chk("R9 tx frames cleared", A_TXF, 0);
        @(negedge clk);
        chk("R9 rd_data zero without read", rd_data, 0);
    endtask

    // R5
    task automatic t_rx_classes;
        rx_ev(1, 16'd200, 1, 0, 0);
        rx_ev(1, 16'd200, 0, 1, 0);
        rx_ev(1, 16'd200, 0, 0, 1);
        rx_ev(1, 16'd200, 1, 0, 0);
        rd_chk("R5 rx bcast", A_RXB, 2);
        rd_chk("R5 rx mcast", A_RXM, 1);
        rd_chk("R5 rx pause", A_RXP, 1);
        rd_chk("R6 bin64 untouched by 200", A_B64, 0);
        rd_chk("R6 bin127 untouched by 200", A_B127, 0);
    endtask

    // R6
    task automatic t_len_bins;
        rx_ev(1, 16'd63, 0, 0, 0);
        rx_ev(1, 16'd64, 0, 0, 0);
        rx_ev(1, 16'd65, 0, 0, 0);
        rx_ev(1, 16'd127, 0, 0, 0);
        rx_ev(1, 16'd128, 0, 0, 0);
        rd_chk("R6 bin exactly 64", A_B64, 1);
        rd_chk("R6 bin 65..127", A_B127, 2);
    endtask

    // R7
    task automatic t_rx_err;
        rx_ev(0, 16'd64, 1, 1, 1);
        rd_chk("R7 error count", A_ERR, 1);
        rd_chk("R7 no bcast", A_RXB, 0);
        rd_chk("R7 no mcast", A_RXM, 0);
        rd_chk("R7 no pause", A_RXP, 0);
        rd_chk("R7 no bin64", A_B64, 0);
    endtask

    // R8
    task automatic t_sat;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            rx_frm_vld = 1; rx_ok = 1; rx_is_mcast = 1; rx_len = 16'd300;
        end
        @(negedge clk);
        rx_frm_vld = 0; rx_ok = 0; rx_is_mcast = 0; rx_len = '0;
        rd_chk("R8 saturated rx mcast", A_RXM, 32'd255);
        rd_chk("R8 cleared after saturation", A_RXM, 0);
    endtask

    // R9
    task automatic t_same_cycle;
        logic [31:0] d;
        tx_ev(16'd1, 0, 0);
        tx_ev(16'd1, 0, 0);
        @(negedge clk);
        rd_en = 1; rd_addr = A_TXF; tx_frm_vld = 1; tx_octets = 16'd1;
        @(negedge clk);
        rd_en = 0; tx_frm_vld = 0; tx_octets = '0;
        d = rd_data;
        chk("R9 read with same-cycle event", d, 2);
        rd_chk("R9 same-cycle event kept", A_TXF, 1);
        rd_chk("R2 octet low clear", A_OLO, 3);
    endtask

    // R3 R8
    task automatic t_oct_split;
        for (int i = 0; i < 65537; i++) begin
            @(negedge clk);
            tx_frm_vld = 1; tx_octets = 16'hFFFF;
        end
        @(negedge clk);
        tx_octets = 16'd10;
        @(negedge clk);
        tx_frm_vld = 0; tx_octets = '0;
        rd_chk("R3 octet low after carry", A_OLO, 32'd9);
        tx_ev(16'd5, 0, 0);
        rd_chk("R3 octet high coherent", A_OHI, 32'd1);
        rd_chk("R3 octet low after clear", A_OLO, 32'd5);
        rd_chk("R3 octet high of new total", A_OHI, 32'd0);
        rd_chk("R8 tx frames saturated", A_TXF, 32'd255);
    endtask

    // R10
    task automatic t_unmapped;
        tx_ev(16'd4, 0, 0);
        rd_chk("R10 below window", 12'h0FC, 0);
        rd_chk("R10 unused slot", 12'h12C, 0);
        rd_chk("R10 window end", 12'h1B0, 0);
        rd_chk("R10 above window", 12'h1B4, 0);
        rd_chk("R10 tx frames not cleared", A_TXF, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_tx_basic();
        t_rx_classes();
        t_len_bins();
        t_rx_err();
        t_sat();
        t_same_cycle();
        t_oct_split();
        t_unmapped();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule